// File: doc/BRIEF.md
# Mixed-Width Dual-Port Synchronous RAM

This block is a true dual-port RAM in which both ports share one storage array but see it at different word widths. The wide port moves 18-bit words over 1024 locations. The narrow port moves 9-bit words over 2048 locations. A producer can therefore write halfwords and a consumer can read full words, or the other way round, with no packing logic outside the block. Every stored byte has its own parity bit, and that bit travels with the byte through both views. The total of 18,432 bits is reachable from either port, and no bits are left unused.

Each port has its own clock, enable, write strobe, synchronous output clear, address, write data and registered read data. On every edge each port decodes its inputs into one of four operations. IDLE applies when the enable is low, and the output register holds. CLEAR applies when the enable and the clear are high: the output register loads a constant and the write is blocked. WRITE applies when the enable and the write strobe are high. READ covers every other enabled edge. A WRITE whose target overlaps a wide-port WRITE on the same edge is downgraded to READ. An elaboration parameter per port sets what that port's own output shows during a WRITE: write-first, read-first or keep.

Top module: `dual_width_ram`

## Requirements
- R1: The wide port has a 10-bit word address and 18-bit data. The narrow port has an 11-bit address and 9-bit data. Both ports map onto the same 18,432 storage bits, and every location at both ends of both address ranges is usable.
- R2: Narrow address n refers to wide word n[10:1]. When n[0]=0 it selects wide bits [7:0] as the narrow data bits [7:0] and wide bit 16 as narrow bit 8. When n[0]=1 it selects wide bits [15:8] and wide bit 17.
- R3: Reads are synchronous. The read data for an address presented before a clock edge appears at the output on that edge.
- R4: While a port's enable is low, its write strobe has no effect on memory and its output register holds its value.
- R5: On an edge where a port is enabled with its clear high, the output register loads that port's reset constant and memory is not written, even with the write strobe high.
- R6: A port in write-first mode shows the data it wrote on the edge of the write.
- R7: A port in read-first mode shows the contents from before the write on the edge of the write.
- R8: A port in keep mode leaves its output register unchanged on a write edge.
- R9: When one port reads a location on the same edge that the other port writes it, the read returns the old contents. A read on a later edge returns the new contents.
- R10: When both ports write overlapping bits on the same edge, the stored value is the wide port's data. On that edge the narrow port's output shows the contents from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Wide-port clock |
| a_en | input | 1 | Wide-port enable |
| a_wr | input | 1 | Wide-port write strobe |
| a_clr | input | 1 | Wide-port synchronous output clear |
| a_addr | input | 10 | Wide-port word address |
| a_wdata | input | 18 | Wide-port write data: bytes at [15:0], parity at [17:16] |
| a_rdata | output | 18 | Wide-port registered read data |
| b_clk | input | 1 | Narrow-port clock |
| b_en | input | 1 | Narrow-port enable |
| b_wr | input | 1 | Narrow-port write strobe |
| b_clr | input | 1 | Narrow-port synchronous output clear |
| b_addr | input | 11 | Narrow-port address |
| b_wdata | input | 9 | Narrow-port write data: byte at [7:0], parity at [8] |
| b_rdata | output | 9 | Narrow-port registered read data |

## Verification
The bench goes after the lane mapping at the edges of both address ranges, with parity bits set in each lane. A swapped lane or a misplaced parity bit shows up as wrong bytes when the data is read back through the other port. It drives same-edge traffic on both ports: a cross-port read of a word being written, and two writes to the same word. A design with the wrong collision rule stores the narrow port's byte or corrupts the whole word, and a design with a bypass returns new data one edge too early. It also checks a write strobe while the port is disabled and a clear with the write strobe high, since a design that lets either reach memory changes data that is read back later. A second instance runs the read-first and keep modes to confirm what each port shows on its own write edge.

// File: rtl/dual_width_ram_pkg.sv
package dual_width_ram_pkg;

    // What a port's own output register shows on its write edge
    typedef enum logic [1:0] {
        RW_WRITE_FIRST = 2'd0,
        RW_READ_FIRST  = 2'd1,
        RW_KEEP        = 2'd2
    } rdw_mode_e;

    // Per-edge decoded operation of one port
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_WRITE = 2'd2,
        PORT_CLEAR = 2'd3
    } port_op_e;

endpackage

// File: rtl/dwr_xor_bank.sv
// One storage bank owned by a single write port. The logical contents are
// the XOR of the two banks, so each bank has exactly one writer.
module dwr_xor_bank #(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] we_lanes,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    x_addr,
    output logic [W-1:0]     own_word,
    output logic [W-1:0]     x_word
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lanes[k]) begin
                mem[waddr] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        assign own_word[k*LANE_W +: LANE_W] = mem[waddr];
        assign x_word[k*LANE_W +: LANE_W]   = mem[x_addr];
    end

endmodule

// File: rtl/dwr_port_ctl.sv
// Operation decode and registered output of one port.
module dwr_port_ctl
    import dual_width_ram_pkg::*;
#(
    parameter int        W       = 18,
    parameter rdw_mode_e MODE    = RW_WRITE_FIRST,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         en,
    input  logic         wr,
    input  logic         clr,
    input  logic         blocked,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cur,
    output port_op_e     op,
    output logic [W-1:0] rdata
);

    logic [W-1:0] wr_view;

    always_comb begin
        if (!en) begin
            op = PORT_IDLE;
        end else if (clr) begin
            op = PORT_CLEAR;
        end else if (wr && !blocked) begin
            op = PORT_WRITE;
        end else begin
            op = PORT_READ;
        end
    end

    if (MODE == RW_WRITE_FIRST) begin : g_wf
        assign wr_view = wdata;
    end else if (MODE == RW_READ_FIRST) begin : g_rf
        assign wr_view = cur;
    end else begin : g_keep
        assign wr_view = rdata;
    end

    always_ff @(posedge clk) begin
        unique case (op)
            PORT_IDLE:  rdata <= rdata;
            PORT_CLEAR: rdata <= RST_VAL;
            PORT_READ:  rdata <= cur;
            PORT_WRITE: rdata <= wr_view;
        endcase
    end

    // Checker state: high from the first edge on
    logic live = 1'b0;
    always_ff @(posedge clk) live <= 1'b1;

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!live)
        !en |=> $stable(rdata));

    // R5
    clear_const_chk: assert property (@(posedge clk) disable iff (!live)
        (en && clr) |=> (rdata == RST_VAL));

    // R3
    read_lat_chk: assert property (@(posedge clk) disable iff (!live)
        (en && !clr && !(wr && !blocked)) |=> (rdata == $past(cur)));

    if (MODE == RW_WRITE_FIRST) begin : g_wf_chk
        // R6
        wf_echo_chk: assert property (@(posedge clk) disable iff (!live)
            (en && !clr && wr && !blocked) |=> (rdata == $past(wdata)));
    end else if (MODE == RW_KEEP) begin : g_keep_chk
        // R8
        keep_hold_chk: assert property (@(posedge clk) disable iff (!live)
            (en && !clr && wr && !blocked) |=> $stable(rdata));
    end else begin : g_rf_chk
        // R7
        rf_old_chk: assert property (@(posedge clk) disable iff (!live)
            (en && !clr && wr && !blocked) |=> (rdata == $past(cur)));
    end

endmodule

// File: rtl/dual_width_ram.sv
module dual_width_ram
    import dual_width_ram_pkg::*;
#(
    parameter int        BYTE_W     = 8,
    parameter int        LANES      = 2,
    parameter int        WIDE_DEPTH = 1024,
    parameter rdw_mode_e MODE_A     = RW_WRITE_FIRST,
    parameter rdw_mode_e MODE_B     = RW_WRITE_FIRST,
    parameter logic [LANES*(BYTE_W+1)-1:0] RST_A = '0,
    parameter logic [BYTE_W:0]             RST_B = '0,
    localparam int LANE_W = BYTE_W + 1,
    localparam int WIDE_W = LANES * LANE_W,
    localparam int BYTES  = LANES * BYTE_W,
    localparam int SEL_W  = $clog2(LANES),
    localparam int WA     = $clog2(WIDE_DEPTH),
    localparam int NA     = WA + SEL_W
) (
    input  logic              a_clk,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_clr,
    input  logic [WA-1:0]     a_addr,
    input  logic [WIDE_W-1:0] a_wdata,
    output logic [WIDE_W-1:0] a_rdata,
    input  logic              b_clk,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_clr,
    input  logic [NA-1:0]     b_addr,
    input  logic [LANE_W-1:0] b_wdata,
    output logic [LANE_W-1:0] b_rdata
);

    // Internal layout: lane k holds {parity k, byte k} at [k*LANE_W +: LANE_W]
    logic [WA-1:0]     b_word;
    logic [SEL_W-1:0]  b_sel;
    logic [WIDE_W-1:0] a_wint, a_cur_int, a_cur_wide;
    logic [WIDE_W-1:0] bA_own, bA_x, bB_own, bB_x;
    logic [WIDE_W-1:0] b_cur_int;
    logic [LANE_W-1:0] b_cur;
    logic [LANES-1:0]  b_mask;
    logic              b_blocked;
    port_op_e          a_op, b_op;

    assign b_word = b_addr[NA-1:SEL_W];
    assign b_sel  = b_addr[SEL_W-1:0];

    // Wide-port view: bytes packed low, parity bits packed above them
    for (genvar k = 0; k < LANES; k++) begin : g_fmt
        assign a_wint[k*LANE_W +: LANE_W] =
            {a_wdata[BYTES + k], a_wdata[k*BYTE_W +: BYTE_W]};
        assign a_cur_wide[k*BYTE_W +: BYTE_W] = a_cur_int[k*LANE_W +: BYTE_W];
        assign a_cur_wide[BYTES + k]          = a_cur_int[k*LANE_W + BYTE_W];
    end

    assign a_cur_int = bA_own ^ bB_x;
    assign b_cur_int = bB_own ^ bA_x;

    always_comb begin
        b_cur  = '0;
        b_mask = '0;
        for (int k = 0; k < LANES; k++) begin
            if (b_sel == SEL_W'(k)) begin
                b_cur     = b_cur_int[k*LANE_W +: LANE_W];
                b_mask[k] = (b_op == PORT_WRITE);
            end
        end
    end

    // Wide port writes every lane of its word, so any same-word write wins
    assign b_blocked = (a_op == PORT_WRITE) && (a_addr == b_word);

    dwr_port_ctl #(
        .W       (WIDE_W),
        .MODE    (MODE_A),
        .RST_VAL (RST_A)
    ) u_ctl_a (
        .clk     (a_clk),
        .en      (a_en),
        .wr      (a_wr),
        .clr     (a_clr),
        .blocked (1'b0),
        .wdata   (a_wdata),
        .cur     (a_cur_wide),
        .op      (a_op),
        .rdata   (a_rdata)
    );

    dwr_port_ctl #(
        .W       (LANE_W),
        .MODE    (MODE_B),
        .RST_VAL (RST_B)
    ) u_ctl_b (
        .clk     (b_clk),
        .en      (b_en),
        .wr      (b_wr),
        .clr     (b_clr),
        .blocked (b_blocked),
        .wdata   (b_wdata),
        .cur     (b_cur),
        .op      (b_op),
        .rdata   (b_rdata)
    );

    dwr_xor_bank #(
        .DEPTH  (WIDE_DEPTH),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_bank_a (
        .clk      (a_clk),
        .we_lanes ({LANES{a_op == PORT_WRITE}}),
        .waddr    (a_addr),
        .wdata    (a_wint ^ bB_x),
        .x_addr   (b_word),
        .own_word (bA_own),
        .x_word   (bA_x)
    );

    dwr_xor_bank #(
        .DEPTH  (WIDE_DEPTH),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_bank_b (
        .clk      (b_clk),
        .we_lanes (b_mask),
        .waddr    (b_word),
        .wdata    ({LANES{b_wdata}} ^ bA_x),
        .x_addr   (a_addr),
        .own_word (bB_own),
        .x_word   (bB_x)
    );

    logic live_a = 1'b0;
    logic live_b = 1'b0;
    always_ff @(posedge a_clk) live_a <= 1'b1;
    always_ff @(posedge b_clk) live_b <= 1'b1;

    // R10
    a_store_chk: assert property (@(posedge a_clk) disable iff (!live_a)
        (a_op == PORT_WRITE) |=>
            (a_addr != $past(a_addr)) || (a_cur_wide == $past(a_wdata)));

    // R2
    b_store_chk: assert property (@(posedge b_clk) disable iff (!live_b)
        (b_op == PORT_WRITE) |=>
            (b_addr != $past(b_addr)) || (b_cur == $past(b_wdata)));

    // R5
    a_clear_nowrite_chk: assert property (@(posedge a_clk) disable iff (!live_a)
        (a_en && a_clr && !b_en) |=>
            (a_addr != $past(a_addr)) || $stable(a_cur_wide));

endmodule

// File: tb/dual_width_ram_bench.sv
module dual_width_ram_bench;
    import dual_width_ram_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_en = 0, a_wr = 0, a_clr = 0;
    logic [9:0]  a_addr = '0;
    logic [17:0] a_wdata = '0;
    logic        b_en = 0, b_wr = 0, b_clr = 0;
    logic [10:0] b_addr = '0;
    logic [8:0]  b_wdata = '0;
    logic [17:0] a1, a2;
    logic [8:0]  b1, b2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [17:0] RA2 = 18'h15A5A;
    localparam logic [8:0]  RB2 = 9'h1C3;

    // Main instance: write-first on both ports, zero reset constants
    dual_width_ram u_dual_width_ram (
        .a_clk(clk), .a_en(a_en), .a_wr(a_wr), .a_clr(a_clr),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a1),
        .b_clk(clk), .b_en(b_en), .b_wr(b_wr), .b_clr(b_clr),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b1)
    );

    // Mode instance: read-first on the wide port, keep on the narrow port
    dual_width_ram #(
        .MODE_A(RW_READ_FIRST), .MODE_B(RW_KEEP), .RST_A(RA2), .RST_B(RB2)
    ) u_dual_width_ram_modes (
        .a_clk(clk), .a_en(a_en), .a_wr(a_wr), .a_clr(a_clr),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a2),
        .b_clk(clk), .b_en(b_en), .b_wr(b_wr), .b_clr(b_clr),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b2)
    );

    // {narrow address, narrow data}
    localparam logic [19:0] NTAB [8] = '{
        {11'd0,    9'h1A5}, {11'd1,    9'h03C}, {11'd6,   9'h100},
        {11'd7,    9'h0FF}, {11'd2046, 9'h155}, {11'd2047, 9'h0AA},
        {11'd700,  9'h1E1}, {11'd701,  9'h012}
    };
    // {wide address, wide data}
    localparam logic [27:0] WTAB [6] = '{
        {10'd5,    18'h3A5C3}, {10'd512, 18'h12345}, {10'd1022, 18'h2FF00},
        {10'd9,    18'h100FF}, {10'd100, 18'h0BEEF}, {10'd7,    18'h3FFFF}
    };

    logic [17:0] ref_mem [1024];

    function automatic logic [8:0] lane_of(input logic [17:0] w, input logic h);
        return h ? {w[17], w[15:8]} : {w[16], w[7:0]};
    endfunction

    task automatic put_lane(input logic [10:0] n, input logic [8:0] d);
        if (n[0]) begin
            ref_mem[n[10:1]][15:8] = d[7:0];
            ref_mem[n[10:1]][17]   = d[8];
        end else begin
            ref_mem[n[10:1]][7:0]  = d[7:0];
            ref_mem[n[10:1]][16]   = d[8];
        end
    endtask

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        a_en = 0; a_wr = 0; a_clr = 0;
        b_en = 0; b_wr = 0; b_clr = 0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [17:0] hold_a, hold_a2;
        logic [8:0]  hold_b, old_lane;
        step();
        step();

        // R5: clear on both ports loads the reset constants
        a_en = 1; a_clr = 1; b_en = 1; b_clr = 1;
        step();
        chk("R5 wide clear", a1, 18'h0);
        chk("R5 narrow clear", {9'h0, b1}, 18'h0);
        chk("R5 wide clear alt", a2, RA2);
        chk("R5 narrow clear alt", {9'h0, b2}, {9'h0, RB2});
        quiet();

        // Zero fill through the wide port
        for (int i = 0; i < 1024; i++) begin
            a_en = 1; a_wr = 1; a_addr = 10'(i); a_wdata = '0;
            ref_mem[i] = '0;
            step();
        end
        quiet();
        b_en = 1; b_clr = 1;
        step();
        quiet();

        // Narrow writes, wide reads
        for (int i = 0; i < 8; i++) begin
            b_en = 1; b_wr = 1;
            b_addr = NTAB[i][19:9]; b_wdata = NTAB[i][8:0];
            put_lane(NTAB[i][19:9], NTAB[i][8:0]);
            step();
            chk("R6 narrow write-first echo", {9'h0, b1}, {9'h0, NTAB[i][8:0]});
            chk("R8 narrow keep holds", {9'h0, b2}, {9'h0, RB2});
        end
        quiet();
        for (int i = 0; i < 8; i++) begin
            a_en = 1; a_addr = NTAB[i][19:10];
            step();
            chk("R2 wide read of narrow data", a1, ref_mem[NTAB[i][19:10]]);
            chk("R3 wide read alt", a2, ref_mem[NTAB[i][19:10]]);
        end
        quiet();

        // Wide writes, narrow reads of both halves
        for (int i = 0; i < 6; i++) begin
            a_en = 1; a_wr = 1;
            a_addr = WTAB[i][27:18]; a_wdata = WTAB[i][17:0];
            hold_a2 = ref_mem[WTAB[i][27:18]];
            ref_mem[WTAB[i][27:18]] = WTAB[i][17:0];
            step();
            chk("R6 wide write-first echo", a1, WTAB[i][17:0]);
            chk("R7 wide read-first old", a2, hold_a2);
        end
        quiet();
        for (int i = 0; i < 6; i++) begin
            for (int h = 0; h < 2; h++) begin
                b_en = 1; b_addr = {WTAB[i][27:18], 1'(h)};
                step();
                chk("R2 narrow read of wide data", {9'h0, b1},
                    {9'h0, lane_of(ref_mem[WTAB[i][27:18]], 1'(h))});
                chk("R1 narrow read alt", {9'h0, b2},
                    {9'h0, lane_of(ref_mem[WTAB[i][27:18]], 1'(h))});
            end
        end
        quiet();

        // R4: disabled ports ignore the write strobe and hold output
        hold_a = a1; hold_b = b1;
        a_en = 0; a_wr = 1; a_addr = 10'd5; a_wdata = 18'h00001;
        b_en = 0; b_wr = 1; b_addr = 11'd14; b_wdata = 9'h1FF;
        step();
        chk("R4 wide output held", a1, hold_a);
        chk("R4 narrow output held", {9'h0, b1}, {9'h0, hold_b});
        quiet();
        a_en = 1; a_addr = 10'd5;
        step();
        chk("R4 wide memory untouched", a1, ref_mem[5]);
        quiet();

        // R5: clear with write strobe does not write memory
        a_en = 1; a_clr = 1; a_wr = 1; a_addr = 10'd512; a_wdata = 18'h01234;
        step();
        chk("R5 clear over write", a1, 18'h0);
        quiet();
        a_en = 1; a_addr = 10'd512;
        step();
        chk("R5 memory kept after clear", a1, ref_mem[512]);
        quiet();

        // R9: cross-port read of a word being written
        old_lane = lane_of(ref_mem[9], 1'b0);
        a_en = 1; a_wr = 1; a_addr = 10'd9; a_wdata = 18'h2C3D4;
        b_en = 1; b_addr = {10'd9, 1'b0};
        ref_mem[9] = 18'h2C3D4;
        step();
        chk("R9 same-edge read old", {9'h0, b1}, {9'h0, old_lane});
        a_wr = 0; a_en = 0;
        step();
        chk("R9 later read new", {9'h0, b1}, {9'h0, lane_of(ref_mem[9], 1'b0)});
        quiet();

        // R10: both ports write the same word on one edge
        old_lane = lane_of(ref_mem[100], 1'b1);
        a_en = 1; a_wr = 1; a_addr = 10'd100; a_wdata = 18'h1A55A;
        b_en = 1; b_wr = 1; b_addr = {10'd100, 1'b1}; b_wdata = 9'h0C3;
        ref_mem[100] = 18'h1A55A;
        step();
        chk("R10 narrow output pre-edge", {9'h0, b1}, {9'h0, old_lane});
        quiet();
        a_en = 1; a_addr = 10'd100;
        b_en = 1; b_addr = {10'd100, 1'b1};
        step();
        chk("R10 wide data stored", a1, 18'h1A55A);
        chk("R10 narrow view of stored", {9'h0, b1}, {9'h0, lane_of(18'h1A55A, 1'b1)});
        quiet();

        // R1: simultaneous writes to different words both land
        a_en = 1; a_wr = 1; a_addr = 10'd7; a_wdata = 18'h05A5A;
        b_en = 1; b_wr = 1; b_addr = {10'd8, 1'b0}; b_wdata = 9'h1AB;
        ref_mem[7] = 18'h05A5A;
        put_lane({10'd8, 1'b0}, 9'h1AB);
        step();
        quiet();
        a_en = 1; a_addr = 10'd8;
        b_en = 1; b_addr = {10'd7, 1'b1};
        step();
        chk("R1 wide sees narrow write", a1, ref_mem[8]);
        chk("R1 narrow sees wide write", {9'h0, b1}, {9'h0, lane_of(ref_mem[7], 1'b1)});
        quiet();

        step();
        done = 1;
        report();
    end

endmodule